// File: doc/BRIEF.md
# Phase-Sequenced Accumulator Controller

This block is the control unit of a small accumulator processor. It does not use one large state machine. The control is split into three small cooperating parts:

- An eight-step phase counter with steps T0 to T7.
- A decoder that turns the two-bit opcode field of the instruction register into one of four instruction kinds.
- A one-bit condition register that holds the accumulator's sign.

The phase counter walks the same step sequence for every instruction. At a few points it looks at the decoded instruction, the held sign and the memory wait line. At those points it may hold its step or return early to T0, so short instructions take fewer cycles.

From the current phase and the decoded instruction, the block drives one strobe per register transfer. These transfers move data among PC, MAR, MBR, IR, AC and memory. The block also drives the memory request and read/write lines. The datapath registers and the memory sit outside the block. They act on the strobes at the same clock edge that advances the phase.

Top module: `phase_seq_ctrl`

## Requirements
- R1: `rst` is synchronous and active high. While it is high, the phase resets to T0, and `t_state` stays one-hot with bit n meaning phase Tn. During reset `pc_clr` is 1 and every other strobe, including `mem_req` and `mem_rd`, is 0. Outside reset `pc_clr` is 0.
- R2: Every instruction steps T0, T1, T2, T3, T4, T5 in that order before any instruction-specific step.
- R3: In T2 the phase holds while `mem_wait` is 1 and moves to T3 in the first cycle it is 0.
- R4: `ir_op` encodes the instruction as 2'b00 load, 2'b01 store, 2'b10 add and 2'b11 branch. It is decoded in the cycle it is presented.
- R5: In T5, a branch returns to T0 when the held sign is non-negative; otherwise the phase goes to T6. The held sign is `ac_msb` (1 = negative) as captured at the previous clock edge.
- R6: In T6, the phase behaves as follows:
  - For load, store or add with `mem_wait` high, it holds in T6.
  - Otherwise a branch, or a store, returns to T0.
  - Load and add go on to T7.
- R7: T7 always returns to T0.
- R8: In T0, `pc_inc` and `pc_to_mar` are 1. In T4, `mbr_to_ir` is 1.
- R9: `mem_req` and `mar_to_abus` are 1 in T2, and in T6 for load, store or add. `mem_rd` is 0 only in T6 of a store. `mdb_to_mbr` is 1 in T2, and in T6 for load or add.
- R10: In T5, `irad_to_mar` is 1 for load, store or add, and `ac_to_mbr` is 1 for store. In T6, `mbr_to_mdb` is 1 for store, and `irad_to_pc` is 1 for branch.
- R11: In T7, `mbr_to_ac` is 1 for load and `ac_add_mbr` is 1 for add. All strobes not named for a phase are 0.
- R12: The accumulator sign drives no strobe. Changing `ac_msb` during a non-branch instruction leaves the strobes and the cycle count unchanged.
- R13: With no waits, each instruction takes this many cycles from T0 to the next T0:

  | Instruction | Cycles |
  |---|---|
  | Branch not taken | 6 |
  | Branch taken | 7 |
  | Store | 7 |
  | Load | 8 |
  | Add | 8 |

  Each wait cycle adds one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_wait | input | 1 | Memory not yet done with the current request |
| ir_op | input | 2 | Opcode field, IR bits 15:14 |
| ac_msb | input | 1 | Accumulator sign bit |
| t_state | output | 8 | One-hot current phase |
| pc_clr | output | 1 | Clear PC |
| pc_inc | output | 1 | Increment PC |
| pc_to_mar | output | 1 | Load MAR from PC |
| mar_to_abus | output | 1 | Drive MAR onto the address bus |
| mdb_to_mbr | output | 1 | Load MBR from the memory data bus |
| mbr_to_mdb | output | 1 | Drive MBR onto the memory data bus |
| mbr_to_ir | output | 1 | Load IR from MBR |
| mbr_to_ac | output | 1 | Load AC from MBR |
| ac_to_mbr | output | 1 | Load MBR from AC |
| ac_add_mbr | output | 1 | Load AC with AC + MBR |
| irad_to_mar | output | 1 | Load MAR from IR bits 13:0 |
| irad_to_pc | output | 1 | Load PC from IR bits 13:0 |
| mem_req | output | 1 | Memory request |
| mem_rd | output | 1 | 1 = read, 0 = write |

## Verification
In T6 of a store, two functions fall in the same cycle:

- the hold on `mem_wait`;
- the write strobes (`mbr_to_mdb` with `mem_rd` low).

If the write window were cut short, or the hold dropped, the stored word or the cycle count would change.

The bench provokes this with a store that meets two wait cycles in T6. It checks three things:

- the cycle count, which must grow by exactly two;
- the strobe vector, which is checked in every cycle;
- the memory word, which the datapath model writes.

A second overlap is the T5 branch decision, which shares its cycle with a change of the sign input. The bench flips `ac_msb` on its own, away from the accumulator value. It then checks that only a branch's length follows the sign.

// File: rtl/phase_seq_pkg.sv
package phase_seq_pkg;

  localparam int OPC_W   = 2;
  localparam int N_PHASE = 8;
  localparam int PH_W    = $clog2(N_PHASE);

  // phases at which sequencing departs from a plain step
  localparam int PH_FETCH_MEM = 2;
  localparam int PH_ADDR      = 5;
  localparam int PH_OPER      = 6;
  localparam int PH_LAST      = N_PHASE - 1;

  typedef enum logic [OPC_W-1:0] {
    OPK_LOAD  = 2'b00,
    OPK_STORE = 2'b01,
    OPK_ADD   = 2'b10,
    OPK_BRAN  = 2'b11
  } opk_e;

  typedef struct packed {
    logic ld;
    logic st;
    logic add;
    logic brn;
  } op_dec_t;

  typedef struct packed {
    logic pc_clr;
    logic pc_inc;
    logic pc_to_mar;
    logic mar_to_abus;
    logic mdb_to_mbr;
    logic mbr_to_mdb;
    logic mbr_to_ir;
    logic mbr_to_ac;
    logic ac_to_mbr;
    logic ac_add_mbr;
    logic irad_to_mar;
    logic irad_to_pc;
    logic mem_req;
    logic mem_rd;
  } xfer_t;

  // instruction kinds that touch memory in the operand phase
  function automatic logic uses_mem(input op_dec_t d);
    return d.ld | d.st | d.add;
  endfunction

  // instruction kinds that read memory in the operand phase
  function automatic logic reads_mem(input op_dec_t d);
    return d.ld | d.add;
  endfunction

endpackage

// File: rtl/op_decoder.sv
module op_decoder
  import phase_seq_pkg::*;
(
  input  logic [OPC_W-1:0] op_field,
  output op_dec_t          dec
);

  always_comb begin
    dec = '0;
    unique case (opk_e'(op_field))
      OPK_LOAD:  dec.ld  = 1'b1;
      OPK_STORE: dec.st  = 1'b1;
      OPK_ADD:   dec.add = 1'b1;
      OPK_BRAN:  dec.brn = 1'b1;
      default:   dec     = '0;
    endcase
  end

endmodule

// File: rtl/sign_tracker.sv
module sign_tracker (
  input  logic clk,
  input  logic rst,
  input  logic sign_in,
  output logic neg_q
);

  always_ff @(posedge clk) begin
    if (rst) neg_q <= 1'b0;
    else     neg_q <= sign_in;
  end

endmodule

// File: rtl/phase_timer.sv
module phase_timer
  import phase_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               mem_wait,
  input  op_dec_t            dec,
  input  logic               cond_neg,
  output logic [N_PHASE-1:0] phase_oh
);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_d;

  always_comb begin
    ph_d = ph_q + 1'b1;
    unique case (ph_q)
      PH_W'(PH_FETCH_MEM): if (mem_wait) ph_d = ph_q;
      PH_W'(PH_ADDR):      if (dec.brn && !cond_neg) ph_d = '0;
      PH_W'(PH_OPER): begin
        if (uses_mem(dec) && mem_wait) ph_d = ph_q;
        else if (dec.brn || dec.st)    ph_d = '0;
      end
      PH_W'(PH_LAST):      ph_d = '0;
      default:             ph_d = ph_q + 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= '0;
    else     ph_q <= ph_d;
  end

  for (genvar i = 0; i < N_PHASE; i++) begin : g_oh
    assign phase_oh[i] = (ph_q == PH_W'(i));
  end

endmodule

// File: rtl/xfer_strobe_gen.sv
module xfer_strobe_gen
  import phase_seq_pkg::*;
(
  input  logic               rst,
  input  logic [N_PHASE-1:0] ph,
  input  op_dec_t            dec,
  output xfer_t              x
);

  always_comb begin
    x = '0;
    if (rst) begin
      x.pc_clr = 1'b1;
    end else begin
      x.pc_inc      = ph[0];
      x.pc_to_mar   = ph[0];
      x.mbr_to_ir   = ph[4];
      x.mem_req     = ph[PH_FETCH_MEM] | (ph[PH_OPER] & uses_mem(dec));
      x.mar_to_abus = x.mem_req;
      x.mdb_to_mbr  = ph[PH_FETCH_MEM] | (ph[PH_OPER] & reads_mem(dec));
      x.mem_rd      = ~(ph[PH_OPER] & dec.st);
      x.irad_to_mar = ph[PH_ADDR] & uses_mem(dec);
      x.ac_to_mbr   = ph[PH_ADDR] & dec.st;
      x.mbr_to_mdb  = ph[PH_OPER] & dec.st;
      x.irad_to_pc  = ph[PH_OPER] & dec.brn;
      x.mbr_to_ac   = ph[PH_LAST] & dec.ld;
      x.ac_add_mbr  = ph[PH_LAST] & dec.add;
    end
  end

endmodule

// File: rtl/phase_seq_ctrl.sv
module phase_seq_ctrl
  import phase_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             mem_wait,
  input  logic [OPC_W-1:0] ir_op,
  input  logic             ac_msb,
  output logic [7:0]       t_state,
  output logic             pc_clr,
  output logic             pc_inc,
  output logic             pc_to_mar,
  output logic             mar_to_abus,
  output logic             mdb_to_mbr,
  output logic             mbr_to_mdb,
  output logic             mbr_to_ir,
  output logic             mbr_to_ac,
  output logic             ac_to_mbr,
  output logic             ac_add_mbr,
  output logic             irad_to_mar,
  output logic             irad_to_pc,
  output logic             mem_req,
  output logic             mem_rd
);

  op_dec_t            dec;
  logic               sign_neg;
  logic [N_PHASE-1:0] phase_oh;
  xfer_t              xf;

  // named events for the checker
  logic is_mem;
  logic is_brn;
  assign is_mem = uses_mem(dec);
  assign is_brn = dec.brn;

  op_decoder u_dec (
    .op_field (ir_op),
    .dec      (dec)
  );

  sign_tracker u_sign (
    .clk     (clk),
    .rst     (rst),
    .sign_in (ac_msb),
    .neg_q   (sign_neg)
  );

  phase_timer u_tmr (
    .clk      (clk),
    .rst      (rst),
    .mem_wait (mem_wait),
    .dec      (dec),
    .cond_neg (sign_neg),
    .phase_oh (phase_oh)
  );

  xfer_strobe_gen u_xfer (
    .rst (rst),
    .ph  (phase_oh),
    .dec (dec),
    .x   (xf)
  );

  assign t_state     = phase_oh;
  assign pc_clr      = xf.pc_clr;
  assign pc_inc      = xf.pc_inc;
  assign pc_to_mar   = xf.pc_to_mar;
  assign mar_to_abus = xf.mar_to_abus;
  assign mdb_to_mbr  = xf.mdb_to_mbr;
  assign mbr_to_mdb  = xf.mbr_to_mdb;
  assign mbr_to_ir   = xf.mbr_to_ir;
  assign mbr_to_ac   = xf.mbr_to_ac;
  assign ac_to_mbr   = xf.ac_to_mbr;
  assign ac_add_mbr  = xf.ac_add_mbr;
  assign irad_to_mar = xf.irad_to_mar;
  assign irad_to_pc  = xf.irad_to_pc;
  assign mem_req     = xf.mem_req;
  assign mem_rd      = xf.mem_rd;

endmodule

// File: rtl/phase_seq_chk.sv
module phase_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       mem_wait,
  input logic [7:0] t_state,
  input logic       sign_neg,
  input logic       is_mem,
  input logic       is_brn,
  input logic       pc_clr,
  input logic       pc_inc,
  input logic       mar_to_abus,
  input logic       mbr_to_mdb,
  input logic       mem_req,
  input logic       mem_rd
);

  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(t_state) == 1); // R1

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |-> (pc_clr && !pc_inc && !mem_req && !mem_rd && !mbr_to_mdb)); // R1

  AST_FETCH_CHAIN: assert property (@(posedge clk) disable iff (rst)
    t_state[0] |=> t_state[1]); // R2

  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (t_state[2] && mem_wait) |=> t_state[2]); // R3

  AST_BRANCH_SHORT: assert property (@(posedge clk) disable iff (rst)
    (t_state[5] && is_brn && !sign_neg) |=> t_state[0]); // R5

  AST_OPER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (t_state[6] && is_mem && mem_wait) |=> t_state[6]); // R6

  AST_LAST_RETURN: assert property (@(posedge clk) disable iff (rst)
    t_state[7] |=> t_state[0]); // R7

  AST_REQ_WINDOW: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> ((t_state[2] || t_state[6]) && mar_to_abus)); // R9

  AST_WRITE_IS_STORE: assert property (@(posedge clk) disable iff (rst)
    !mem_rd |-> (mem_req && mbr_to_mdb && t_state[6])); // R9

endmodule

bind phase_seq_ctrl phase_seq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .mem_wait    (mem_wait),
  .t_state     (t_state),
  .sign_neg    (sign_neg),
  .is_mem      (is_mem),
  .is_brn      (is_brn),
  .pc_clr      (pc_clr),
  .pc_inc      (pc_inc),
  .mar_to_abus (mar_to_abus),
  .mbr_to_mdb  (mbr_to_mdb),
  .mem_req     (mem_req),
  .mem_rd      (mem_rd)
);

// File: tb/sim_phase_seq_ctrl.sv
`timescale 1ns/100ps
module sim_phase_seq_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mem_wait;
  logic [1:0] ir_op;
  logic ac_msb;
  logic [7:0] t_state;
  logic pc_clr, pc_inc, pc_to_mar, mar_to_abus, mdb_to_mbr, mbr_to_mdb;
  logic mbr_to_ir, mbr_to_ac, ac_to_mbr, ac_add_mbr, irad_to_mar, irad_to_pc;
  logic mem_req, mem_rd;

  always #2.5 clk = ~clk;

  phase_seq_ctrl u0 (
    .clk(clk), .rst(rst), .mem_wait(mem_wait), .ir_op(ir_op), .ac_msb(ac_msb),
    .t_state(t_state), .pc_clr(pc_clr), .pc_inc(pc_inc), .pc_to_mar(pc_to_mar),
    .mar_to_abus(mar_to_abus), .mdb_to_mbr(mdb_to_mbr), .mbr_to_mdb(mbr_to_mdb),
    .mbr_to_ir(mbr_to_ir), .mbr_to_ac(mbr_to_ac), .ac_to_mbr(ac_to_mbr),
    .ac_add_mbr(ac_add_mbr), .irad_to_mar(irad_to_mar), .irad_to_pc(irad_to_pc),
    .mem_req(mem_req), .mem_rd(mem_rd)
  );

  // ---------------- datapath and memory model ----------------
  logic [15:0] mem [64];
  logic [15:0] pc, ir, ac, mbr;
  logic [13:0] mar;
  int fw_req = 0, ow_req = 0;   // wait cycles the memory inserts (bench-set)
  int fw_used, ow_used;          // wait cycles already spent (model-owned)
  logic flip = 1'b0;             // sign noise, bench-set

  assign ir_op  = ir[15:14];
  assign ac_msb = ac[15] ^ flip;
  assign mem_wait = (t_state[2] && fw_used < fw_req) || (t_state[6] && ow_used < ow_req);

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) mem[i] <= 16'h0;
      mem[0]  <= 16'h0028;  // LD 40
      mem[1]  <= 16'h8029;  // ADD 41
      mem[2]  <= 16'h402A;  // ST 42
      mem[3]  <= 16'hC00A;  // BRN 10
      mem[4]  <= 16'h002B;  // LD 43
      mem[5]  <= 16'hC014;  // BRN 20
      mem[20] <= 16'h402C;  // ST 44
      mem[21] <= 16'h0028;  // LD 40
      mem[22] <= 16'h8029;  // ADD 41
      mem[23] <= 16'hC01E;  // BRN 30
      mem[30] <= 16'h402D;  // ST 45
      mem[40] <= 16'h0005;
      mem[41] <= 16'h0003;
      mem[43] <= 16'h8001;
      if (pc_clr) pc <= 16'h0;
      ir <= 16'h0; ac <= 16'h0; mbr <= 16'h0; mar <= 14'h0;
      fw_used <= 0; ow_used <= 0;
    end else begin
      if (pc_inc)      pc  <= pc + 16'd1;
      if (irad_to_pc)  pc  <= {2'b00, ir[13:0]};
      if (pc_to_mar)   mar <= pc[13:0];
      if (irad_to_mar) mar <= ir[13:0];
      if (mdb_to_mbr && mem_req && mem_rd) mbr <= mem[mar[5:0]];
      if (ac_to_mbr)   mbr <= ac;
      if (mbr_to_ir)   ir  <= mbr;
      if (mbr_to_ac)   ac  <= mbr;
      if (ac_add_mbr)  ac  <= ac + mbr;
      if (mem_req && !mem_rd && mbr_to_mdb) mem[mar[5:0]] <= mbr;
      if (t_state[0]) begin fw_used <= 0; ow_used <= 0; end
      if (t_state[2] && mem_wait) fw_used <= fw_used + 1;
      if (t_state[6] && mem_wait) ow_used <= ow_used + 1;
    end
  end

  // ---------------- per-cycle strobe monitor (R8..R11) ----------------
  int mon_chk = 0, mon_fail = 0;
  always @(negedge clk) begin
    if (!rst) begin
      logic ld, st, ad, br, req;
      logic [13:0] exp_v, act_v;
      ld = (ir_op == 2'b00); st = (ir_op == 2'b01);
      ad = (ir_op == 2'b10); br = (ir_op == 2'b11);
      req = t_state[2] | (t_state[6] & !br);
      exp_v = {1'b0, t_state[0], t_state[0], req,
               t_state[2] | (t_state[6] & (ld | ad)),
               t_state[6] & st, t_state[4], t_state[7] & ld,
               t_state[5] & st, t_state[7] & ad,
               t_state[5] & !br, t_state[6] & br, req,
               !(t_state[6] & st)};
      act_v = {pc_clr, pc_inc, pc_to_mar, mar_to_abus, mdb_to_mbr, mbr_to_mdb,
               mbr_to_ir, mbr_to_ac, ac_to_mbr, ac_add_mbr, irad_to_mar,
               irad_to_pc, mem_req, mem_rd};
      mon_chk++;
      if (act_v !== exp_v || $countones(t_state) != 1) begin
        mon_fail++;
        $display("FAIL R8/R9/R10/R11 strobes t=%b: actual %b expected %b", t_state, act_v, exp_v);
      end
    end
  end

  // ---------------- directed scenarios ----------------
  int tk_chk = 0, tk_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    tk_chk++;
    if (act !== exp_v) begin
      tk_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
    end
  endtask

  // run one instruction from T0 until the next T0, return the cycle count
  task automatic run_instr(input int fw, input int ow, input bit noise, output int cyc);
    fw_req = fw; ow_req = ow;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (noise) flip = ~flip;
    end while (t_state != 8'h01 && cyc < 60);
    flip = 1'b0;
  endtask

  task automatic tk_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 phase in reset", {24'h0, t_state}, 32'h01);
    chk("R1 pc_clr in reset", {31'h0, pc_clr}, 32'h1);
    chk("R1 other strobes in reset",
        {18'h0, pc_inc, pc_to_mar, mar_to_abus, mdb_to_mbr, mbr_to_mdb, mbr_to_ir,
         mbr_to_ac, ac_to_mbr, ac_add_mbr, irad_to_mar, irad_to_pc, mem_req, mem_rd}, 32'h0);
    rst = 1'b0;
  endtask

  task automatic tk_load_add();
    int c;
    chk("R2 start at T0", {24'h0, t_state}, 32'h01);
    run_instr(0, 0, 1'b0, c);
    chk("R13 load cycles", c, 8);
    chk("R11 load result", {16'h0, ac}, 32'h5);
    run_instr(0, 0, 1'b0, c);
    chk("R13 add cycles", c, 8);
    chk("R11 add result", {16'h0, ac}, 32'h8);
  endtask

  task automatic tk_store();
    int c;
    run_instr(0, 0, 1'b0, c);
    chk("R6 store cycles", c, 7);
    chk("R10 stored word", {16'h0, mem[42]}, 32'h8);
  endtask

  task automatic tk_branch_not();
    int c;
    run_instr(0, 0, 1'b0, c);
    chk("R5 branch not taken cycles", c, 6);
    chk("R5 pc after not taken", {16'h0, pc}, 32'h4);
  endtask

  task automatic tk_branch_taken();
    int c;
    run_instr(0, 0, 1'b0, c);
    chk("R4 load negative value", {16'h0, ac}, 32'h8001);
    run_instr(0, 0, 1'b0, c);
    chk("R5 branch taken cycles", c, 7);
    chk("R10 pc after taken", {16'h0, pc}, 32'd20);
  endtask

  task automatic tk_store_wait();
    int c;
    run_instr(0, 2, 1'b0, c);
    chk("R6 store with two operand waits", c, 9);
    chk("R9 stored word under wait", {16'h0, mem[44]}, 32'h8001);
  endtask

  task automatic tk_fetch_wait();
    int c;
    run_instr(3, 1, 1'b0, c);
    chk("R3 load with fetch and operand waits", c, 12);
    chk("R3 load result under waits", {16'h0, ac}, 32'h5);
  endtask

  task automatic tk_sign_noise();
    int c;
    run_instr(0, 0, 1'b1, c);
    chk("R12 add cycles under sign noise", c, 8);
    chk("R12 add result under sign noise", {16'h0, ac}, 32'h8);
    // sign seen as negative through the input although AC is positive
    flip = 1'b1;
    fw_req = 0; ow_req = 0;
    c = 0;
    do begin @(negedge clk); c++; end while (t_state != 8'h01 && c < 60);
    flip = 1'b0;
    chk("R5 branch follows sampled sign", c, 7);
    chk("R5 pc after sign-driven branch", {16'h0, pc}, 32'd30);
    run_instr(2, 0, 1'b0, c);
    chk("R3 store with fetch waits", c, 9);
    chk("R10 stored word after waits", {16'h0, mem[45]}, 32'h8);
  endtask

  task automatic tk_mid_reset();
    while (!t_state[3]) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset mid instruction phase", {24'h0, t_state}, 32'h01);
    chk("R1 reset mid instruction pc_clr", {31'h0, pc_clr}, 32'h1);
    @(negedge clk);
    chk("R1 pc cleared", {16'h0, pc}, 32'h0);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    $display("FAIL R13 watchdog: actual run still going, expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", tk_chk + mon_chk + 1, tk_fail + mon_fail + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    tk_reset();
    tk_load_add();
    tk_store();
    tk_branch_not();
    tk_branch_taken();
    tk_store_wait();
    tk_fetch_wait();
    tk_sign_noise();
    tk_mid_reset();
    $display("== %0d vectors applied, %0d miscompares ==", tk_chk + mon_chk, tk_fail + mon_fail);
    $finish;
  end

endmodule